// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that sits in front of a 512-byte storage array. In this design the array is built from flip-flops. A bus master addresses the block with a 7-bit device address. The upper four bits of that address are the fixed code `1010`. The next two bits must equal the two strap inputs, so up to four of these blocks can share one bus. The last address bit picks which 256-byte half of the array the access uses. A word-address byte then gives the location inside that half.

The master can write one byte or a page of up to eight bytes. It can also do a random read: a dummy write that sets the address, then a repeated START and a read. A sequential read can follow and continues over any number of bytes. A write-protect input guards the upper half of the array. When it is high, data bytes aimed at the upper half get no acknowledge and the array does not change.

After a write ends with STOP, the block enters a busy period. During that period it refuses its own device address. The busy period lasts a parameterised number of pulses on a clock-enable input. SDA is driven open-drain: an output enable pulls the line low. Both bus lines are oversampled and resynchronised by the system clock.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the block does not pull SDA low.
- R2: The block acknowledges an address byte only when bits 7:4 are `1010`, bit 3 equals `strap_a2`, bit 2 equals `strap_a1`, and no busy period is running. Any other address byte gets no acknowledge, and the block ignores the bus until the next START or STOP.
- R3: In a write, the byte after the address byte is the word address. Each data byte after it is stored at the current location and acknowledged.
- R4: During a write, the location advances only in its low three bits. It wraps inside the aligned 8-byte page and leaves the upper bits unchanged.
- R5: In a read, the block sends the byte at the current location MSB first and then advances the location by one. A dummy write followed by a repeated START and a read returns the byte at the given word address.
- R6: A sequential read continues while the master acknowledges each byte. The location increments across all 9 bits, so it steps from 255 to 256 and wraps from 511 to 0.
- R7: Bit 1 of the address byte becomes bit 8 of the location: 0 selects locations 0 to 255, 1 selects 256 to 511.
- R8: While `wr_protect` is high, a data byte whose location has bit 8 set gets no acknowledge and is not stored. Data bytes to the lower half are still stored.
- R9: A STOP that ends a write in which at least one byte was stored starts a busy period of `BUSY_TICKS` pulses of `tick_en`. The device address gets no acknowledge until the last of these pulses. A write in which no byte was stored starts no busy period.
- R10: START and STOP are falling and rising SDA edges while SCL is high. A STOP at any point returns the block to idle with SDA released. The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_a1 | input | 1 | Address strap compared with address bit 2 |
| strap_a2 | input | 1 | Address strap compared with address bit 3 |
| wr_protect | input | 1 | High blocks writes to the upper half |
| tick_en | input | 1 | Clock enable that times the busy period |

## Verification
The assertions assume a well-formed bus. SDA changes only while SCL is low, except for START and STOP. Each SCL phase lasts several system clocks, so the two-flop synchronisers see every level. The bench master holds each SCL quarter for six system clocks and drives SDA only in the low phase. It releases SDA in every bit slot where the target may drive. The write-protect input is held steady for the whole of a transaction. `tick_en` pulses only when the bench is waiting out a busy period, so the busy window can be counted pulse by pulse.

// File: rtl/eep_pkg.sv
// Package: shared constants and the protocol state type for the EEPROM target.
// Assumes a 7-bit device address whose upper nibble is a fixed family code.
package eep_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,   // bus free, waiting for START
        ST_DEV,    // shifting in the device address byte
        ST_WORD,   // shifting in the word address byte
        ST_WDATA,  // shifting in a write data byte
        ST_ACK,    // target drives ACK for one SCL clock
        ST_RD,     // target shifts a read byte out
        ST_RDACK,  // master answers ACK/NACK to a read byte
        ST_WAIT    // transaction not ours or ended; wait for START/STOP
    } bus_state_t;

endpackage

// File: rtl/eep_sync.sv
// Module: eep_sync
// Resynchronises SCL and SDA into clk with two flops each and derives
// SCL edges plus START/STOP events. Assumes SCL phases last several clks.
module eep_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_m, sda_m;
    logic scl_d, sda_d;

    // Two-stage synchronisers plus a delayed copy for edge detection; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            sda_m <= 1'b1;
            scl_s <= 1'b1;
            sda_s <= 1'b1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_m <= scl_in;
            sda_m <= sda_in;
            scl_s <= scl_m;
            sda_s <= sda_m;
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Edge and bus-condition decode from current and delayed synchronised levels.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/eep_busy_timer.sv
// Module: eep_busy_timer
// Counts the internal erase/write busy window in tick_en pulses.
// Assumes start is a single-cycle pulse issued only when no window is running.
module eep_busy_timer #(
    parameter int BUSY_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick_en,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_TICKS + 1);

    logic [CNT_W-1:0] cnt;

    // Load on start, count down one per enabled tick while non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(BUSY_TICKS);
        end else if (tick_en && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    assert_busy_countdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tick_en && !start) |=> (cnt == $past(cnt) - 1'b1));

    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick_en && !start) |=> busy);

endmodule

// File: rtl/eep_array.sv
// Module: eep_array
// Flop-based storage with one registered write port and one combinational
// read port. Contents are not reset, modelling retained data.
module eep_array #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 8
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store one byte when the controller commits a write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/eep_ctrl.sv
// Module: eep_ctrl
// Bus protocol engine: address decode, word address, page writes with
// in-page wrap, write-protect refusal, sequential reads and ACK drive.
// Assumes synchronised bus signals and single-cycle edge/condition strobes.
module eep_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              strap_a1,
    input  logic              strap_a2,
    input  logic              wr_protect,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic              busy_start,
    output logic              sda_oe
);
    localparam int WORD_W = ADDR_W - 1;

    bus_state_t        state, after_ack;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg;
    logic [ADDR_W-1:0] ptr;
    logic              wrote;
    logic              master_ack;
    logic              addr_hit;
    logic              wp_block;

    // Device address match against family code, straps and busy window.
    always_comb begin
        addr_hit = (shreg[7:4] == DEV_CODE) && (shreg[3] == strap_a2)
                && (shreg[2] == strap_a1) && !busy;
        wp_block = wr_protect && ptr[ADDR_W-1];
    end

    assign rd_addr = ptr;

    // Protocol sequencer: shifts bits, decides ACKs, moves the location pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            after_ack  <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            ptr        <= '0;
            wrote      <= 1'b0;
            master_ack <= 1'b0;
            mem_we     <= 1'b0;
            mem_waddr  <= '0;
            mem_wdata  <= '0;
            busy_start <= 1'b0;
            sda_oe     <= 1'b0;
        end else begin
            mem_we     <= 1'b0;
            busy_start <= 1'b0;
            if (start_det) begin
                state  <= ST_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                if (wrote) begin
                    busy_start <= 1'b1;
                    wrote      <= 1'b0;
                end
            end else begin
                case (state)
                    ST_DEV, ST_WORD, ST_WDATA: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (state == ST_DEV) begin
                                if (addr_hit) begin
                                    sda_oe          <= 1'b1;
                                    ptr[ADDR_W-1]   <= shreg[1];
                                    after_ack       <= shreg[0] ? ST_RD : ST_WORD;
                                    state           <= ST_ACK;
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end else if (state == ST_WORD) begin
                                sda_oe           <= 1'b1;
                                ptr[WORD_W-1:0]  <= shreg[WORD_W-1:0];
                                after_ack        <= ST_WDATA;
                                state            <= ST_ACK;
                            end else if (wp_block) begin
                                state <= ST_WAIT;
                            end else begin
                                sda_oe            <= 1'b1;
                                mem_we            <= 1'b1;
                                mem_waddr         <= ptr;
                                mem_wdata         <= shreg;
                                ptr[PAGE_W-1:0]   <= ptr[PAGE_W-1:0] + 1'b1;
                                wrote             <= 1'b1;
                                after_ack         <= ST_WDATA;
                                state             <= ST_ACK;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (after_ack == ST_RD) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                ptr    <= ptr + 1'b1;
                            end else begin
                                sda_oe <= 1'b0;
                            end
                            state <= after_ack;
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RDACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    ST_RDACK: begin
                        if (scl_rise) begin
                            master_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (master_ack) begin
                                bitcnt <= '0;
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                ptr    <= ptr + 1'b1;
                                state  <= ST_RD;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    assert_release_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    assert_drive_only_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> (!scl_s || $past(stop_det) || $past(start_det)));

    assert_wp_no_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !($past(wr_protect) && mem_waddr[ADDR_W-1]));

    assert_page_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (ptr[ADDR_W-1:PAGE_W] == mem_waddr[ADDR_W-1:PAGE_W]
                    && ptr[PAGE_W-1:0] == mem_waddr[PAGE_W-1:0] + 1'b1));

    assert_busy_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV && scl_fall && bitcnt == 4'd8 && busy && !start_det && !stop_det)
        |=> (state == ST_WAIT && !sda_oe));

endmodule

// File: rtl/i2c_eeprom_target.sv
// Module: i2c_eeprom_target
// Top level: I2C target for a 512-byte array with strap-selected address,
// page writes, sequential reads, upper-half write protect and a busy window.
// Assumes clk runs many times faster than SCL; SDA is open-drain via sda_oe.
module i2c_eeprom_target #(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 8,
    parameter int BUSY_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe,
    input  logic strap_a1,
    input  logic strap_a2,
    input  logic wr_protect,
    input  logic tick_en
);
    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              busy, busy_start, mem_we;
    logic [ADDR_W-1:0] rd_addr, mem_waddr;
    logic [7:0]        rd_data, mem_wdata;

    eep_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eep_ctrl #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .strap_a1   (strap_a1),
        .strap_a2   (strap_a2),
        .wr_protect (wr_protect),
        .busy       (busy),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .busy_start (busy_start),
        .sda_oe     (sda_oe)
    );

    eep_busy_timer #(
        .BUSY_TICKS (BUSY_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (busy_start),
        .tick_en (tick_en),
        .busy    (busy)
    );

    eep_array #(
        .DEPTH (MEM_BYTES),
        .WIDTH (8)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: tb/tb_i2c_eeprom_target.sv
// Bench: a bus-master driver issues transactions and pushes the expected
// read bytes into a scoreboard queue; a monitor pops and compares each byte.
module tb_i2c_eeprom_target;
    localparam int Q  = 6;
    localparam int BT = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic strap_a1 = 1'b0;
    logic strap_a2 = 1'b1;
    logic wr_protect = 1'b0;
    logic tick_en = 1'b0;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_val[$];
    string      exp_tag[$];
    logic [7:0] rx_data;
    event       rx_ev;
    logic [7:0] wbuf [8];

    always #2 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2c_eeprom_target #(.BUSY_TICKS(BT)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (m_scl),
        .sda_in     (sda_line),
        .sda_oe     (sda_oe),
        .strap_a1   (strap_a1),
        .strap_a2   (strap_a2),
        .wr_protect (wr_protect),
        .tick_en    (tick_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; w(Q);
        m_scl = 1'b1; w(Q);
        m_sda = 1'b0; w(Q);
        m_scl = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; w(Q);
        m_scl = 1'b1; w(Q);
        m_sda = 1'b1; w(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; w(Q);
            m_scl = 1'b1; w(Q);
            m_scl = 1'b0; w(Q);
        end
        m_sda = 1'b1; w(Q);
        m_scl = 1'b1; w(Q);
        acked = ~sda_line;
        m_scl = 1'b0; w(Q);
    endtask

    task automatic recv_byte(input bit ack_it);
        logic [7:0] b;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            m_scl = 1'b1; w(Q);
            b[i] = sda_line;
            m_scl = 1'b0; w(Q);
        end
        m_sda = ~ack_it; w(Q);
        m_scl = 1'b1; w(Q);
        m_scl = 1'b0; w(Q);
        m_sda = 1'b1;
        rx_data = b;
        -> rx_ev;
    endtask

    function automatic logic [7:0] dev(input bit p, input bit rd);
        return {4'b1010, strap_a2, strap_a1, p, rd};
    endfunction

    task automatic expect_byte(input string tag, input logic [7:0] v);
        exp_tag.push_back(tag);
        exp_val.push_back(v);
    endtask

    task automatic let_busy_end();
        for (int i = 0; i < BT + 2; i++) begin
            tick_en = 1'b1; w(1);
            tick_en = 1'b0; w(2);
        end
    endtask

    // Write n bytes from wbuf at {p, wa}; every byte is expected to be acknowledged.
    task automatic do_write(input bit p, input logic [7:0] wa, input int n, input string tag);
        bit a;
        bus_start();
        send_byte(dev(p, 1'b0), a); chk({tag, " dev ack"}, a, 1);
        send_byte(wa, a);           chk({tag, " word ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);  chk({tag, " data ack"}, a, 1);
        end
        bus_stop();
        let_busy_end();
    endtask

    // Random read of n bytes from {p, wa}; last byte NACKed then STOP.
    task automatic do_read(input bit p, input logic [7:0] wa, input int n, input string tag);
        bit a;
        bus_start();
        send_byte(dev(p, 1'b0), a); chk({tag, " rd dev ack"}, a, 1);
        send_byte(wa, a);           chk({tag, " rd word ack"}, a, 1);
        bus_start();
        send_byte(dev(p, 1'b1), a); chk({tag, " rd dev2 ack"}, a, 1);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1);
        bus_stop();
        w(4);
    endtask

    // Scoreboard monitor: compare each received byte with the queue head.
    initial begin
        forever begin
            @(rx_ev);
            if (exp_val.size() == 0) begin
                chk("R5 unexpected read byte", rx_data, 32'hFFFF_FFFF);
            end else begin
                string t;
                logic [7:0] v;
                t = exp_tag.pop_front();
                v = exp_val.pop_front();
                chk(t, rx_data, v);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit a;
        w(5);
        rst_n = 1'b1;
        w(5);
        chk("R1 sda released after reset", sda_oe, 0);

        // R2: wrong strap bits and wrong family code are ignored
        bus_start();
        send_byte({4'b1010, ~strap_a2, strap_a1, 2'b00}, a);
        chk("R2 strap a2 mismatch nack", a, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1010, strap_a2, ~strap_a1, 2'b00}, a);
        chk("R2 strap a1 mismatch nack", a, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, strap_a2, strap_a1, 2'b00}, a);
        chk("R2 family code mismatch nack", a, 0);
        bus_stop();
        w(4);

        // R3/R5: byte write then random read
        wbuf[0] = 8'h3C;
        do_write(1'b0, 8'h05, 1, "R3 byte write");
        expect_byte("R5 random read of 0x005", 8'h3C);
        do_read(1'b0, 8'h05, 1, "R5");

        // R4: page write starting at offset 6 wraps to the page start
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
        do_write(1'b0, 8'h16, 4, "R4 page write");
        expect_byte("R4 wrap byte at 0x010", 8'hC3);
        expect_byte("R4 wrap byte at 0x011", 8'hD4);
        do_read(1'b0, 8'h10, 2, "R4");
        expect_byte("R4 byte at 0x016", 8'hA1);
        expect_byte("R4 byte at 0x017", 8'hB2);
        do_read(1'b0, 8'h16, 2, "R4");

        // R7: half select by address bit 1
        wbuf[0] = 8'hA5;
        do_write(1'b1, 8'h05, 1, "R7 upper write");
        expect_byte("R7 lower 0x005 unchanged", 8'h3C);
        do_read(1'b0, 8'h05, 1, "R7");
        expect_byte("R7 upper 0x105", 8'hA5);
        do_read(1'b1, 8'h05, 1, "R7");

        // R6: sequential read across 255->256 and 511->0
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        do_write(1'b0, 8'hFE, 2, "R6 prep 0x0FE");
        wbuf[0] = 8'h33; wbuf[1] = 8'h44;
        do_write(1'b1, 8'h00, 2, "R6 prep 0x100");
        wbuf[0] = 8'h55; wbuf[1] = 8'h66;
        do_write(1'b1, 8'hFE, 2, "R6 prep 0x1FE");
        wbuf[0] = 8'h77; wbuf[1] = 8'h88;
        do_write(1'b0, 8'h00, 2, "R6 prep 0x000");
        expect_byte("R6 seq 0x0FE", 8'h11);
        expect_byte("R6 seq 0x0FF", 8'h22);
        expect_byte("R6 seq 0x100", 8'h33);
        expect_byte("R6 seq 0x101", 8'h44);
        do_read(1'b0, 8'hFE, 4, "R6");
        expect_byte("R6 seq 0x1FE", 8'h55);
        expect_byte("R6 seq 0x1FF", 8'h66);
        expect_byte("R6 wrap 0x000", 8'h77);
        expect_byte("R6 wrap 0x001", 8'h88);
        do_read(1'b1, 8'hFE, 4, "R6");

        // R8: write protect on the upper half
        wbuf[0] = 8'h5E;
        do_write(1'b1, 8'h20, 1, "R8 prep 0x120");
        wr_protect = 1'b1;
        bus_start();
        send_byte(dev(1'b1, 1'b0), a); chk("R8 dev ack with wp", a, 1);
        send_byte(8'h20, a);           chk("R8 word ack with wp", a, 1);
        send_byte(8'h99, a);           chk("R8 upper data nack", a, 0);
        bus_stop();
        w(4);
        // R9: refused write stored nothing so no busy window
        bus_start();
        send_byte(dev(1'b0, 1'b0), a); chk("R9 no busy after refused write", a, 1);
        bus_stop();
        w(4);
        expect_byte("R8 upper 0x120 unchanged", 8'h5E);
        do_read(1'b1, 8'h20, 1, "R8");
        wbuf[0] = 8'h6B;
        do_write(1'b0, 8'h30, 1, "R8 lower write under wp");
        expect_byte("R8 lower 0x030 stored", 8'h6B);
        do_read(1'b0, 8'h30, 1, "R8");
        wr_protect = 1'b0;

        // R9: busy window counted in tick_en pulses
        bus_start();
        send_byte(dev(1'b0, 1'b0), a); chk("R9 dev ack", a, 1);
        send_byte(8'h40, a);           chk("R9 word ack", a, 1);
        send_byte(8'hE7, a);           chk("R9 data ack", a, 1);
        bus_stop();
        w(4);
        bus_start();
        send_byte(dev(1'b0, 1'b0), a); chk("R9 nack at busy start", a, 0);
        bus_stop();
        for (int i = 0; i < BT - 1; i++) begin
            tick_en = 1'b1; w(1);
            tick_en = 1'b0; w(2);
        end
        bus_start();
        send_byte(dev(1'b0, 1'b0), a); chk("R9 nack one tick before end", a, 0);
        bus_stop();
        tick_en = 1'b1; w(1);
        tick_en = 1'b0; w(2);
        bus_start();
        send_byte(dev(1'b0, 1'b0), a); chk("R9 ack after last tick", a, 1);
        bus_stop();
        w(4);

        // R10: STOP in the middle of an address byte returns to idle
        bus_start();
        for (int i = 7; i >= 5; i--) begin
            m_sda = dev(1'b0, 1'b0) >> i; w(Q);
            m_scl = 1'b1; w(Q);
            m_scl = 1'b0; w(Q);
        end
        bus_stop();
        w(4);
        chk("R10 sda released after stop", sda_oe, 0);
        expect_byte("R10 read after aborted byte", 8'hE7);
        do_read(1'b0, 8'h40, 1, "R10");
        chk("R10 sda released after nack+stop", sda_oe, 0);

        w(20);
        chk("R5 scoreboard drained", exp_val.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule